// File: doc/BRIEF.md
# Serial-Frame Infrared Pulse Encoder

This block turns a requested infrared pulse length, given in microseconds, into a run of asynchronous serial characters whose bit pattern stands in for a carrier of about 38 kHz. Each character goes out as seven data bits with no parity and one stop bit, at a nominal 115200 bit/s. With its start bit, a character spans nine bit-times, which is close to three carrier periods. A low bit-time on the serial line lights the emitter. A space between pulses needs nothing from the block: the caller just leaves it idle for the space length.

On a start request the block converts the length into raw bit-times, then fills characters one carrier period (one "group" of three bit-times) at a time. A full character is handed to a one-deep holding stage as soon as that stage is free, so frames follow each other with no gap. A final partly filled character is also sent. The block then waits until the serial line has gone fully idle. Finally it reports a residual: the number of microseconds by which the emitted time went past the request. The caller subtracts this from the space that follows.

Top module: `ir_frame_encoder`

## Requirements
- R1: After reset, `busy` is 0, `txLine` is 1 (idle) and `residual` is 0.
- R2: A `start` pulse seen while `busy` is 0 raises `busy` on the next clock. A `start` seen while `busy` is 1 is ignored: the pulse in progress, its residual and the return to idle are unchanged, and no second run begins.
- R3: The raw bit count is floor(L * 1152 / 10000) for L = `pulseLen`. The number of groups is ceil(raw / 3) and the number of frames is ceil(groups / 3). When raw is 0, no frame is sent.
- R4: Each frame on `txLine` is a low start bit, then data bits 0 to 6 (least significant first), then a high stop bit. Every bit lasts CLKS_PER_BIT clocks, and consecutive frames of one pulse follow each other with no idle time between them.
- R5: With `dutyHigh` = 0, group j (0 to 2) of a frame drives one low bit-time at frame position 3j. Position 0 is the start bit, position 3 is data bit 2 and position 6 is data bit 5. A frame with three groups therefore carries data 0x5B.
- R6: With `dutyHigh` = 1, group j drives two low bit-times, at frame positions 3j and 3j+1. These are the start bit with data bit 0, data bits 2 and 3, and data bits 5 and 6. A frame with three groups carries data 0x12.
- R7: In a last frame that holds only one or two groups, the data bits of the missing groups stay high.
- R8: When `busy` falls, `residual` is set to floor(rem * 10000 / 1152), plus floor((3 - i) * 30000 / 1152) when i is not 0. Here rem = 3 * groups - raw and i = groups mod 3. At any other time `residual` holds its value.
- R9: `busy` falls only after the stop bit of the last frame has ended. Whenever `busy` is 0, `txLine` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to emit one pulse, sampled while idle |
| pulseLen | input | LEN_W | Pulse length in microseconds |
| dutyHigh | input | 1 | 1 selects two low bit-times per carrier period, 0 selects one |
| busy | output | 1 | High from the clock after `start` until the line is idle again |
| txLine | output | 1 | Serial output line, idle high, low lights the emitter |
| residual | output | RES_W | Overshoot of the emitted time in microseconds |

## Verification
Two things can fall in the same clock. The first is the control pushing the next character into the holding stage. The second is the shifter finishing a stop bit and pulling the holding stage into a fresh frame. The bench provokes this on every multi-frame pulse, with lengths long enough that the next character is always waiting when the stop bit ends. It samples every bit-time at its centre against frames built from R4 to R7. A stray idle bit, a lost character or a doubled frame between back-to-back frames shows up as a bit mismatch or as an extra low level after the expected last stop bit.

// File: rtl/irfe_pkg.sv
package irfe_pkg;

  // strobes from control to the serial datapath
  typedef struct packed {
    logic       push;
    logic [6:0] chr;
  } txCmd_t;

  // datapath condition seen by the control
  typedef struct packed {
    logic holdFree;
    logic lineIdle;
  } txStat_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CALC, ST_GROUP, ST_PUSH, ST_DRAIN
  } ctrlState_e;

  // data bits to clear for carrier group idx: chunk placed at 3*idx, minus one for start bit
  function automatic logic [6:0] groupMask(input logic [1:0] idx, input logic wide);
    logic [7:0] s;
    s = (wide ? 8'd3 : 8'd1) << (3 * idx);
    return s[7:1];
  endfunction

  // overshoot in microseconds from leftover raw bits and last group index
  function automatic int residualUs(input int remBits, input int lastGrp, input int bitNum);
    int r;
    r = (remBits * 10000) / bitNum;
    if (lastGrp != 0) r = r + ((3 - lastGrp) * 3 * 10000) / bitNum;
    return r;
  endfunction

endpackage

// File: rtl/irfe_ctrl.sv
module irfe_ctrl
  import irfe_pkg::*;
#(
  parameter int LEN_W     = 16,
  parameter int RES_W     = 8,
  parameter int BAUD_RATE = 115200
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [LEN_W-1:0] pulseLen,
  input  logic             dutyHigh,
  input  txStat_t          stat,
  output txCmd_t           cmd,
  output logic             busy,
  output logic [RES_W-1:0] residual
);
  localparam int BIT_NUM = BAUD_RATE / 100;
  localparam int BIT_DEN = 10000;
  localparam int PROD_W  = LEN_W + $clog2(BIT_NUM + 1);

  ctrlState_e              state;
  logic [LEN_W-1:0]        lenReg;
  logic                    wide;
  logic signed [LEN_W:0]   rawLeft;
  logic [1:0]              grp;
  logic [6:0]              chr;
  logic                    closing;
  logic [1:0]              remBits;

  assign remBits = 2'(0 - rawLeft);
  assign busy    = (state != ST_IDLE);
  assign cmd.push = (state == ST_PUSH) && stat.holdFree;
  assign cmd.chr  = chr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      lenReg   <= '0;
      wide     <= 1'b0;
      rawLeft  <= '0;
      grp      <= '0;
      chr      <= 7'h7F;
      closing  <= 1'b0;
      residual <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          lenReg <= pulseLen;
          wide   <= dutyHigh;
          state  <= ST_CALC;
        end
        ST_CALC: begin
          rawLeft <= (LEN_W+1)'((PROD_W'(lenReg) * PROD_W'(BIT_NUM)) / PROD_W'(BIT_DEN));
          grp     <= '0;
          chr     <= 7'h7F;
          closing <= 1'b0;
          state   <= ST_GROUP;
        end
        ST_GROUP: begin
          if (grp == 2'd3) begin
            closing <= 1'b0;
            state   <= ST_PUSH;
          end else if (rawLeft > 0) begin
            chr     <= chr & ~groupMask(grp, wide);
            rawLeft <= rawLeft - (LEN_W+1)'(3);
            grp     <= grp + 2'd1;
          end else if (grp != 2'd0) begin
            closing <= 1'b1;
            state   <= ST_PUSH;
          end else begin
            state <= ST_DRAIN;
          end
        end
        ST_PUSH: if (stat.holdFree) begin
          chr <= 7'h7F;
          if (closing) begin
            state <= ST_DRAIN;
          end else begin
            grp   <= '0;
            state <= ST_GROUP;
          end
        end
        ST_DRAIN: if (stat.lineIdle) begin
          residual <= RES_W'(residualUs(int'(remBits), int'(grp), BIT_NUM));
          state    <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/irfe_tx.sv
module irfe_tx
  import irfe_pkg::*;
#(
  parameter int CLKS_PER_BIT = 868
) (
  input  logic    clk,
  input  logic    rstN,
  input  txCmd_t  cmd,
  output txStat_t stat,
  output logic    txLine
);
  localparam int DIV_W = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
  localparam int LAST_BIT = 8;

  logic             holdValid;
  logic [6:0]       holdData;
  logic             shActive;
  logic [8:0]       shReg;
  logic [3:0]       bitIdx;
  logic [DIV_W-1:0] divCnt;

  assign stat.holdFree = !holdValid;
  assign stat.lineIdle = !holdValid && !shActive;
  assign txLine = shActive ? shReg[0] : 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdValid <= 1'b0;
      holdData  <= '0;
      shActive  <= 1'b0;
      shReg     <= '1;
      bitIdx    <= '0;
      divCnt    <= '0;
    end else begin
      if (cmd.push) begin
        holdValid <= 1'b1;
        holdData  <= cmd.chr;
      end
      if (!shActive) begin
        if (holdValid) begin
          shActive  <= 1'b1;
          shReg     <= {1'b1, holdData, 1'b0};
          bitIdx    <= '0;
          divCnt    <= '0;
          holdValid <= 1'b0;
        end
      end else if (divCnt == DIV_W'(CLKS_PER_BIT - 1)) begin
        divCnt <= '0;
        if (bitIdx == 4'(LAST_BIT)) begin
          if (holdValid) begin
            shReg     <= {1'b1, holdData, 1'b0};
            bitIdx    <= '0;
            holdValid <= 1'b0;
          end else begin
            shActive <= 1'b0;
          end
        end else begin
          shReg  <= {1'b1, shReg[8:1]};
          bitIdx <= bitIdx + 4'd1;
        end
      end else begin
        divCnt <= divCnt + DIV_W'(1);
      end
    end
  end
endmodule

// File: rtl/ir_frame_encoder.sv
module ir_frame_encoder
  import irfe_pkg::*;
#(
  parameter int LEN_W        = 16,
  parameter int RES_W        = 8,
  parameter int BAUD_RATE    = 115200,
  parameter int CLKS_PER_BIT = 868
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [LEN_W-1:0] pulseLen,
  input  logic             dutyHigh,
  output logic             busy,
  output logic             txLine,
  output logic [RES_W-1:0] residual
);
  txCmd_t  cmd;
  txStat_t stat;

  irfe_ctrl #(.LEN_W(LEN_W), .RES_W(RES_W), .BAUD_RATE(BAUD_RATE)) ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .pulseLen(pulseLen),
    .dutyHigh(dutyHigh), .stat(stat), .cmd(cmd), .busy(busy), .residual(residual)
  );

  irfe_tx #(.CLKS_PER_BIT(CLKS_PER_BIT)) tx_i (
    .clk(clk), .rstN(rstN), .cmd(cmd), .stat(stat), .txLine(txLine)
  );
endmodule

// File: rtl/irfe_chk.sv
module irfe_chk #(
  parameter int RES_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             busy,
  input logic             txLine,
  input logic [RES_W-1:0] residual
);
  assert_idle_high_R9: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> txLine);

  assert_fall_in_run_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(txLine) |-> busy);

  assert_busy_cause_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start));

  assert_residual_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(residual) |-> $fell(busy));

  assert_residual_bound_R8: assert property (@(posedge clk) disable iff (!rstN)
    residual <= RES_W'(69));
endmodule

bind ir_frame_encoder irfe_chk #(.RES_W(RES_W)) chk_i (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy), .txLine(txLine), .residual(residual)
);

// File: tb/ir_frame_encoder_tb_top.sv
module ir_frame_encoder_tb_top;
  localparam int CPB = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        dutyHigh = 1'b0;
  logic [15:0] pulseLen = '0;
  logic        busy, txLine;
  logic [7:0]  residual;

  int checks = 0;
  int bad = 0;

  ir_frame_encoder #(.CLKS_PER_BIT(CPB)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .pulseLen(pulseLen),
    .dutyHigh(dutyHigh), .busy(busy), .txLine(txLine), .residual(residual)
  );

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int rawOf(input int L);
    return (L * 1152) / 10000;
  endfunction

  function automatic int expResidual(input int L);
    int raw, g, rem, i, r;
    raw = rawOf(L);
    g = (raw + 2) / 3;
    rem = 3 * g - raw;
    i = g % 3;
    r = (rem * 10000) / 1152;
    if (i != 0) r += ((3 - i) * 30000) / 1152;
    return r;
  endfunction

  // expected line level at overall bit-time k of the pulse
  function automatic bit expBit(input int groups, input bit hi, input int k);
    int frame, pos, j, off;
    frame = k / 9;
    pos = k % 9;
    j = pos / 3;
    off = pos % 3;
    if (frame * 3 + j < groups && (off == 0 || (off == 1 && hi))) return 1'b0;
    return 1'b1;
  endfunction

  task automatic runPulse(input int L, input bit hi, input bit poke);
    int raw, groups, nChars, errs, waitN, extraLow;
    string ftag;
    raw = rawOf(L);
    groups = (raw + 2) / 3;
    nChars = (groups + 2) / 3;
    ftag = (groups % 3 != 0) ? "R7 partial frame" : (hi ? "R6 wide frame" : "R5 narrow frame");
    @(negedge clk);
    pulseLen = 16'(L);
    dutyHigh = hi;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R2 busy after start", int'(busy), 1);
    if (nChars > 0) begin
      waitN = 0;
      while (txLine == 1'b1 && waitN < 60) begin
        @(negedge clk);
        waitN++;
      end
      check(waitN < 60, "R4 first start bit", waitN, 0);
      errs = 0;
      @(negedge clk);
      for (int b = 0; b < nChars * 9; b++) begin
        if (b > 0) begin
          @(negedge clk);
          start = 1'b0;
          repeat (CPB - 1) @(negedge clk);
        end
        if (txLine != expBit(groups, hi, b)) errs++;
        if (poke && b == 3) begin
          start = 1'b1;
          pulseLen = 16'(L + 333);
          dutyHigh = ~hi;
        end
      end
      check(errs == 0, {ftag, " R4 bits"}, errs, 0);
    end
    extraLow = 0;
    waitN = 0;
    while (busy == 1'b1 && waitN < 80) begin
      if (txLine == 1'b0) extraLow++;
      @(negedge clk);
      waitN++;
    end
    check(busy == 1'b0, "R9 busy falls after last stop", int'(busy), 0);
    check(extraLow == 0, "R3 frame count", extraLow, 0);
    check(int'(residual) == expResidual(L), "R8 residual", int'(residual), expResidual(L));
    check(txLine == 1'b1, "R9 idle line", int'(txLine), 1);
    if (poke) begin
      repeat (6) @(negedge clk);
      check(busy == 1'b0, "R2 start while busy ignored", int'(busy), 0);
      check(txLine == 1'b1, "R2 no second run", int'(txLine), 1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=150000 expected=fewer cycles");
    $display("  test done: total=%0d bad=%0d", checks + 1, bad);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R1 reset busy", int'(busy), 0);
    check(txLine == 1'b1, "R1 reset line", int'(txLine), 1);
    check(residual == 8'd0, "R1 reset residual", int'(residual), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(busy == 1'b0 && txLine == 1'b1, "R1 idle after release", int'(busy), 0);
    // directed corner cases of the raw count and last group index
    runPulse(0, 1'b0, 1'b0);
    runPulse(8, 1'b1, 1'b0);
    runPulse(9, 1'b0, 1'b0);
    runPulse(9, 1'b1, 1'b0);
    runPulse(26, 1'b0, 1'b0);
    runPulse(27, 1'b1, 1'b0);
    runPulse(78, 1'b0, 1'b0);
    runPulse(79, 1'b1, 1'b0);
    runPulse(79, 1'b0, 1'b0);
    runPulse(500, 1'b1, 1'b1);
    runPulse(500, 1'b0, 1'b0);
    // random lengths and duty choices
    for (int n = 0; n < 24; n++) begin
      runPulse(int'($urandom_range(700, 0)), 1'($urandom_range(1, 0)), (n % 6) == 5);
    end
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule